// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block finds the bit rate of a host that talks to a UART before any real data is exchanged. While alignment runs, the host keeps sending the character 0x00 in an 8-data-bit, 1-stop-bit, no-parity frame. For that character the receive line stays low for nine bit times: the start bit plus eight zero data bits. The block times each such low span and snaps it to the nearest legal rate (9600, 4800 or 2400 bps). Once two measurements in a row agree, it loads the matching divisor (system clocks per bit) into its divisor output for the companion UART.

Locking is permanent until reset. On the cycle the lock is taken, the block pulses a request for exactly one cycle, so that the transmit side sends a single 0x00 byte back to the host to confirm alignment. The enable input gates measurement. The raw line passes through a synchronizer and a glitch filter, so short spikes cannot start or end a span.

Top module: `abd_autobaud`

## Requirements
- R1: After a synchronous active-low reset, locked_o is 0, ack_req_o is 0 and divisor_o is 0.
- R2: A filtered low span of W clocks is matched to rate r (9600, 4800, 2400) when W lies within ±WIN_PCT percent (default 8) of 9*(CLK_HZ/r). When the block locks on r, divisor_o becomes CLK_HZ/r.
- R3: One valid span alone never locks. Lock is taken when a span matches the same rate as the span just before it and differs from that earlier span by at most (earlier >> AGREE_SHIFT) clocks (default shift 5, about 3%).
- R4: A valid span that fails the agreement test gives no lock and becomes the new reference. A following span that agrees with it locks.
- R5: A span that matches no rate window is discarded and clears the reference, so two more agreeing spans are needed before lock.
- R6: Low pulses shorter than (CLK_HZ/9600)/4 clocks are filtered out. They neither end, start nor count as a span, and the widths of longer spans are kept exactly.
- R7: locked_o stays 1 until reset and divisor_o does not change while locked. ack_req_o is high for exactly one cycle, the cycle locked_o first reads 1, and never again before reset.
- R8: While en_i is 0, no measurement is made and no lock is taken. A low span whose falling edge happened while en_i was 0 is not measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Raw asynchronous serial receive line, idle high |
| en_i | input | 1 | Enables measurement and locking |
| divisor_o | output | DIV_W | Clocks per bit of the locked rate, 0 before lock |
| locked_o | output | 1 | Rate locked, sticky until reset |
| ack_req_o | output | 1 | One-cycle request to transmit the 0x00 acknowledgement |

## Verification
The hardest situation to reach from the ports is a pair of spans that both fall inside one rate window but differ by just more than the agreement tolerance, because ordinary jitter rarely lands there. The bench drives such a pair directly, with widths 900 and 870 clocks at 9600 bps against a tolerance of 28. Around these directed cases, seeded random sequences mix rates, ±3% jitter and out-of-window spans, and a bench model predicts, after every character, whether lock should be held. Glitches just below and just above the filter length, and a span that begins while disabled, are also driven directly.

// File: rtl/abd_pkg.sv
// Shared constants for the automatic baud rate detector.
// Rate index 0 is the fastest rate; all modules use this ordering.
package abd_pkg;
    localparam int NUM_RATES    = 3;
    localparam int BITS_PER_LOW = 9;   // start bit plus eight zero data bits

    // Legal host rate for a given rate index.
    function automatic int rate_bps(input int idx);
        case (idx)
            0:       return 9600;
            1:       return 4800;
            default: return 2400;
        endcase
    endfunction
endpackage

// File: rtl/abd_sync_filter.sv
// Synchronizes the raw receive line and removes short spikes.
// The output changes only after the synchronized input has disagreed with it
// for FILT consecutive clocks, so both edges are delayed equally and the
// widths of accepted pulses are kept. Assumes the line idles high.
module abd_sync_filter #(
    parameter int FILT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT + 1);

    logic          sync1, sync2;
    logic [CW-1:0] run_cnt;

    // Two-flop synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rx_i;
            sync2 <= sync1;
        end
    end

    // Count disagreement time and flip the filtered level once it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o  <= 1'b1;
            run_cnt <= '0;
        end else if (sync2 == line_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT - 1)) begin
            line_o  <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/abd_low_timer.sv
// Measures the length, in clocks, of each low span of the filtered line.
// A span is measured only when its falling edge is seen while enabled.
// meas_valid_o pulses on the first high cycle after the span; meas_cnt_o holds
// the width and saturates at CNT_MAX.
module abd_low_timer #(
    parameter int CNT_W   = 20,
    parameter int CNT_MAX = 1000,
    parameter int MIN_LOW = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             line_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_cnt_o
);
    logic prev_line;
    logic busy;

    // Track the previous level to find falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_line <= 1'b1;
        else        prev_line <= line_i;
    end

    // Start on a falling edge, count while low, report on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            meas_valid_o <= 1'b0;
            meas_cnt_o   <= '0;
        end else begin
            meas_valid_o <= 1'b0;
            if (!en_i) begin
                busy <= 1'b0;
            end else if (prev_line && !line_i) begin
                busy       <= 1'b1;
                meas_cnt_o <= CNT_W'(1);
            end else if (busy && !line_i) begin
                if (meas_cnt_o != CNT_W'(CNT_MAX))
                    meas_cnt_o <= meas_cnt_o + 1'b1;
            end else if (busy && line_i) begin
                busy         <= 1'b0;
                meas_valid_o <= 1'b1;
            end
        end
    end

    // The glitch filter upstream must never let a short span reach the timer.
    assert_min_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> (meas_cnt_o >= CNT_W'(MIN_LOW)));
endmodule

// File: rtl/abd_rate_snap.sv
// Compares a measured low span against an acceptance window around the
// nominal nine-bit span of every legal rate. The windows are fixed at
// elaboration and must not overlap (WIN_PCT well below 33).
module abd_rate_snap
    import abd_pkg::*;
#(
    parameter int CLK_HZ  = 48_000_000,
    parameter int WIN_PCT = 8,
    parameter int CNT_W   = 20
) (
    input  logic [CNT_W-1:0]     cnt_i,
    output logic [NUM_RATES-1:0] hit_o
);
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
        localparam longint NOM9 = longint'(BITS_PER_LOW) * longint'(CLK_HZ / rate_bps(g));
        localparam longint LO   = NOM9 * (100 - WIN_PCT) / 100;
        localparam longint HI   = NOM9 * (100 + WIN_PCT) / 100;
        // One window comparator per legal rate.
        assign hit_o[g] = (cnt_i >= CNT_W'(LO)) && (cnt_i <= CNT_W'(HI));
    end

    // A span may fall in at most one window (R2).
    always_comb begin
        assert_single_rate_R2: assert ($onehot0(hit_o));
    end
endmodule

// File: rtl/abd_lock_judge.sv
// Holds the previous valid measurement as a reference and decides when the
// current one agrees with it. An unmatched span clears the reference; a
// matched span that disagrees replaces it. fire_o is combinational and valid
// in the cycle meas_valid_i is high.
module abd_lock_judge
    import abd_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int AGREE_SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 meas_valid_i,
    input  logic [CNT_W-1:0]     meas_cnt_i,
    input  logic [NUM_RATES-1:0] hit_i,
    output logic                 fire_o
);
    logic                 ref_valid;
    logic [CNT_W-1:0]     ref_cnt;
    logic [NUM_RATES-1:0] ref_hit;
    logic [CNT_W-1:0]     diff;
    logic                 agree;

    // Absolute difference and agreement test against the reference.
    always_comb begin
        diff   = (meas_cnt_i >= ref_cnt) ? (meas_cnt_i - ref_cnt) : (ref_cnt - meas_cnt_i);
        agree  = ref_valid && (|hit_i) && (hit_i == ref_hit) && (diff <= (ref_cnt >> AGREE_SHIFT));
        fire_o = en_i && meas_valid_i && agree;
    end

    // Update the reference after each measurement.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            ref_valid <= 1'b0;
            ref_cnt   <= '0;
            ref_hit   <= '0;
        end else if (meas_valid_i) begin
            ref_valid <= |hit_i;
            ref_cnt   <= meas_cnt_i;
            ref_hit   <= hit_i;
        end
    end

    // A lock decision needs a reference taken from an earlier span (R3).
    assert_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ref_valid);
endmodule

// File: rtl/abd_autobaud.sv
// Automatic baud rate detector top level.
// Times the low span of repeated 0x00 characters, snaps it to one of the legal
// rates, and locks after two agreeing spans. On lock it loads the divisor
// (clocks per bit), raises a sticky lock flag and pulses a one-cycle request
// for the acknowledgement byte. Assumes 8N1 framing from the host.
module abd_autobaud
    import abd_pkg::*;
#(
    parameter int CLK_HZ      = 48_000_000,
    parameter int WIN_PCT     = 8,
    parameter int AGREE_SHIFT = 5,
    localparam int DIV_FAST   = CLK_HZ / rate_bps(0),
    localparam int DIV_SLOW   = CLK_HZ / rate_bps(NUM_RATES - 1),
    localparam int DIV_W      = $clog2(DIV_SLOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             en_i,
    output logic [DIV_W-1:0] divisor_o,
    output logic             locked_o,
    output logic             ack_req_o
);
    localparam int FILT    = DIV_FAST / 4;
    localparam int CNT_MAX = 2 * BITS_PER_LOW * DIV_SLOW;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic                 line;
    logic                 meas_valid;
    logic [CNT_W-1:0]     meas_cnt;
    logic [NUM_RATES-1:0] hit;
    logic                 fire;
    logic [DIV_W-1:0]     div_tab [NUM_RATES];
    logic [DIV_W-1:0]     div_sel;

    abd_sync_filter #(.FILT(FILT)) filt_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .line_o(line)
    );

    abd_low_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .MIN_LOW(FILT)) timer_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .line_i(line),
        .meas_valid_o(meas_valid), .meas_cnt_o(meas_cnt)
    );

    abd_rate_snap #(.CLK_HZ(CLK_HZ), .WIN_PCT(WIN_PCT), .CNT_W(CNT_W)) snap_i (
        .cnt_i(meas_cnt), .hit_o(hit)
    );

    abd_lock_judge #(.CNT_W(CNT_W), .AGREE_SHIFT(AGREE_SHIFT)) judge_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .meas_valid_i(meas_valid),
        .meas_cnt_i(meas_cnt), .hit_i(hit), .fire_o(fire)
    );

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
        // Divisor constant for each legal rate.
        assign div_tab[g] = DIV_W'(CLK_HZ / rate_bps(g));
    end

    // Pick the divisor of the rate window that matched.
    always_comb begin
        div_sel = '0;
        for (int k = 0; k < NUM_RATES; k++)
            if (hit[k]) div_sel = div_tab[k];
    end

    // Take the lock once, load the divisor and pulse the acknowledgement request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o  <= 1'b0;
            ack_req_o <= 1'b0;
            divisor_o <= '0;
        end else begin
            ack_req_o <= 1'b0;
            if (fire && !locked_o) begin
                locked_o  <= 1'b1;
                ack_req_o <= 1'b1;
                divisor_o <= div_sel;
            end
        end
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |=> !ack_req_o);
    assert_ack_on_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> (locked_o && !$past(locked_o)));
    assert_div_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> $stable(divisor_o));
    assert_no_lock_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !locked_o) |=> !locked_o);
    assert_lock_has_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (divisor_o != '0));
endmodule

// File: tb/abd_autobaud_tb.sv
module abd_autobaud_tb_top;
    localparam int CLK_HZ = 960_000;
    localparam int DIV_W  = $clog2(CLK_HZ / 2400 + 1);
    localparam int GAP    = 150;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic             en = 1'b0;
    logic [DIV_W-1:0] divisor;
    logic             locked;
    logic             ack_req;

    int n_checks = 0;
    int n_fail   = 0;
    int ack_seen = 0;
    int ack_base = 0;
    bit done     = 1'b0;

    // Bench model state.
    bit m_ref_valid;
    int m_ref_cnt;
    int m_ref_cls;
    bit m_locked;
    int m_div;

    always #4 clk = ~clk;

    abd_autobaud #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .en_i(en),
        .divisor_o(divisor), .locked_o(locked), .ack_req_o(ack_req)
    );

    always @(posedge clk) if (ack_req) ack_seen++;

    function automatic int rate_of(input int idx);
        return (idx == 0) ? 9600 : (idx == 1) ? 4800 : 2400;
    endfunction

    function automatic int nom9(input int idx);
        return 9 * (CLK_HZ / rate_of(idx));
    endfunction

    // R2 window match: index of the rate, or -1.
    function automatic int classify(input int w);
        for (int k = 0; k < 3; k++)
            if (w >= nom9(k) * 92 / 100 && w <= nom9(k) * 108 / 100) return k;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx = 1'b1; en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ack_base = ack_seen;
        m_ref_valid = 0; m_locked = 0; m_div = 0; m_ref_cnt = 0; m_ref_cls = -1;
        repeat (2) @(negedge clk);
    endtask

    // Model update per span seen while enabled (R3, R4, R5).
    task automatic model_span(input int w);
        int c;
        c = classify(w);
        if (c < 0) begin
            m_ref_valid = 0;
        end else if (m_ref_valid && c == m_ref_cls &&
                     ((w > m_ref_cnt ? w - m_ref_cnt : m_ref_cnt - w) <= (m_ref_cnt >> 5))) begin
            if (!m_locked) begin m_locked = 1; m_div = CLK_HZ / rate_of(c); end
            m_ref_valid = 1; m_ref_cnt = w; m_ref_cls = c;
        end else begin
            m_ref_valid = 1; m_ref_cnt = w; m_ref_cls = c;
        end
    endtask

    task automatic send_span(input int w);
        @(negedge clk);
        rx = 1'b0;
        repeat (w) @(negedge clk);
        rx = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic span_and_model(input int w);
        send_span(w);
        if (en) model_span(w);
    endtask

    task automatic check_model(input string req);
        check(locked == m_locked, req, "locked", int'(locked), int'(m_locked));
        check(int'(divisor) == m_div, req, "divisor", int'(divisor), m_div);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        do_reset();
        check(locked == 1'b0, "R1", "locked after reset", int'(locked), 0);
        check(ack_req == 1'b0, "R1", "ack after reset", int'(ack_req), 0);
        check(divisor == '0, "R1", "divisor after reset", int'(divisor), 0);

        // R2, R3: 9600 bps, first span alone does not lock
        span_and_model(900);
        check(locked == 1'b0, "R3", "locked after one span", int'(locked), 0);
        span_and_model(902);
        check(locked == 1'b1, "R3", "locked after two spans", int'(locked), 1);
        check(int'(divisor) == 100, "R2", "divisor 9600", int'(divisor), 100);
        check(ack_seen - ack_base == 1, "R7", "ack pulses", ack_seen - ack_base, 1);

        // R7: further characters at another rate change nothing
        span_and_model(1800);
        span_and_model(1800);
        check(int'(divisor) == 100, "R7", "divisor held", int'(divisor), 100);
        check(locked == 1'b1, "R7", "lock held", int'(locked), 1);
        check(ack_seen - ack_base == 1, "R7", "no second ack", ack_seen - ack_base, 1);

        // R2: 4800 and 2400 lock to their divisors
        do_reset();
        span_and_model(1790); span_and_model(1810);
        check(int'(divisor) == 200, "R2", "divisor 4800", int'(divisor), 200);
        do_reset();
        span_and_model(3600); span_and_model(3650);
        check(int'(divisor) == 400, "R2", "divisor 2400", int'(divisor), 400);

        // R4: just beyond tolerance (30 > 28), then agreement
        do_reset();
        span_and_model(900); span_and_model(870);
        check(locked == 1'b0, "R4", "no lock on disagreement", int'(locked), 0);
        span_and_model(870);
        check(locked == 1'b1, "R4", "lock after new reference", int'(locked), 1);

        // R5: out-of-window span clears reference
        do_reset();
        span_and_model(900); span_and_model(1200); span_and_model(900);
        check(locked == 1'b0, "R5", "no lock after discard", int'(locked), 0);
        span_and_model(900);
        check(locked == 1'b1, "R5", "lock after two fresh spans", int'(locked), 1);

        // R6: 20-clock glitch ignored, 30-clock one is a span
        do_reset();
        span_and_model(900); send_span(20); span_and_model(900);
        check(locked == 1'b1, "R6", "glitch ignored", int'(locked), 1);
        do_reset();
        span_and_model(900); span_and_model(30); span_and_model(900);
        check(locked == 1'b0, "R6", "long pulse measured", int'(locked), 0);

        // R8: disabled spans are not measured
        do_reset();
        en = 1'b0;
        span_and_model(900); span_and_model(900);
        check(locked == 1'b0, "R8", "no lock while disabled", int'(locked), 0);
        // span beginning while disabled, enabled mid-span
        @(negedge clk); rx = 1'b0;
        repeat (300) @(negedge clk);
        en = 1'b1;
        repeat (600) @(negedge clk);
        rx = 1'b1;
        repeat (GAP) @(negedge clk);
        span_and_model(900);
        check(locked == 1'b0, "R8", "partial span not measured", int'(locked), 0);
        span_and_model(900);
        check(locked == 1'b1, "R8", "lock after enable", int'(locked), 1);

        // Random sequences checked against the model (R2..R5, R7)
        for (int t = 0; t < 12; t++) begin
            do_reset();
            for (int c = 0; c < 4; c++) begin
                int idx, j, w;
                idx = int'($urandom_range(0, 2));
                j = nom9(idx) * 3 / 100;
                if ($urandom_range(0, 5) == 0) w = int'($urandom_range(300, 700));
                else w = nom9(idx) + int'($urandom_range(0, 2 * j)) - j;
                span_and_model(w);
                check_model("R3");
            end
            check(ack_seen - ack_base == int'(m_locked), "R7", "random ack count",
                  ack_seen - ack_base, int'(m_locked));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule